// File: doc/BRIEF.md
# I2C EEPROM-Emulation Slave Bridge

This block lets an I2C master treat a word-organised flash array as a byte-addressed serial EEPROM of up to 1024 bytes (512 by default). It detects start, repeated-start and stop conditions on synchronised SCL and SDA lines. It answers a 7-bit device address whose upper nibble is a parameter and whose lower bits come from strap pins. It acknowledges bytes by pulling SDA low and never drives it high.

Writes are gathered into a page buffer and handed to the memory only after the master's stop condition. While that hand-off or the memory's own internal cycle is running, the device address is not acknowledged, so the master can poll for completion. Reads use an address pointer that is loaded by a dummy write and advances once per byte sent. A write-protect input blocks data writes and erases. When an erase-trigger parameter is set, a device address with its A2 position set requests an erase of the sector that holds the byte address that follows.

The memory side uses two ports. The write port is valid/ready: `wr_valid` rises only after a stop. While `wr_ready` is low, `wr_valid`, `wr_addr`, `wr_data` and `wr_erase` hold steady. Each accepted beat is one byte write, or one sector erase when `wr_erase` is high. `mem_busy` reports the memory's internal cycle. The read port is plain: `rd_data` must show the byte at `rd_addr` combinationally. The core clock must run at least 8 times the SCL rate.

Top module: `eei2c_slave`

## Requirements
- R1: After reset, SDA is released (`sda_pull_o` = 0) and no write request is raised.
- R2: A device byte is acknowledged only if bits 7:4 equal `DEV_HI` (1010 by default) and bits 3:2 equal `dev_pins[2:1]`. Bit 1 is also compared with `dev_pins[0]` when `ADDR_W` is 8. Bit 0 = 1 means read and 0 means write. On a mismatch the slave stays silent until the next start.
- R3: With `ADDR_W` = 9, bit 1 of the device byte becomes bit 8 of the byte address.
- R4: A byte write (device byte, address byte, one data byte, each acknowledged) leaves the memory untouched until stop. After the stop it is issued as one write beat to that address.
- R5: A page write acknowledges up to `PAGE_BYTES` (16) data bytes. It commits them after stop to consecutive addresses starting at the byte address. Any further data byte is not acknowledged and is dropped.
- R6: While committed bytes are still pending or `mem_busy` is high, the device byte is not acknowledged.
- R7: With `wp_i` high, the device and address bytes are acknowledged, the first data byte is not, and nothing is written.
- R8: With a write device byte whose bit 3 (A2) is 1, the A2 pin is not compared. The next byte (with R3's bit 8) is acknowledged and one erase beat (`wr_erase` = 1) for its sector is issued after stop. With `wp_i` high, that byte is not acknowledged and nothing is issued.
- R9: A read device byte starts sending from the pointer, MSB first, one byte per master ACK. The pointer advances per byte sent. After a master NACK, SDA stays released. A dummy write of the address followed by a repeated start gives a random read.
- R10: A start or repeated start before a stop discards the data bytes received in that frame.
- R11: `sda_pull_o` never changes while SCL is high.
- R12: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr`, `wr_data` and `wr_erase` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, at least 8x SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | I2C clock line level |
| sda_i | input | 1 | I2C data line level |
| sda_pull_o | output | 1 | 1 pulls SDA low, 0 releases it |
| dev_pins | input | 3 | Strap levels for A2, A1, A0 |
| wp_i | input | 1 | Write protect |
| wr_valid | output | 1 | Write/erase beat offered |
| wr_ready | input | 1 | Memory takes the beat |
| wr_addr | output | ADDR_W | Byte address of the beat |
| wr_data | output | 8 | Byte to write |
| wr_erase | output | 1 | Beat is a sector erase |
| mem_busy | input | 1 | Memory internal cycle running |
| rd_addr | output | ADDR_W | Read pointer |
| rd_data | input | 8 | Byte at rd_addr |

## Verification
A wrong decode of the device byte shows up at the ninth SCL pulse of that byte. A stray or missing ACK is visible on SDA within one bit time. A broken pointer or page counter stays hidden until readback. The bench therefore reads every written location back over I2C or from its memory model after the commit drains, often thousands of cycles later. A premature commit shows up before the stop, because the bench inspects the memory between the last data byte and the stop. Back-pressure and SDA-timing faults are watched every cycle.

// File: rtl/eei2c_pkg.sv
package eei2c_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_DEV, ST_ADDR, ST_WDATA, ST_RDATA, ST_IGNORE
  } phase_e;
endpackage

// File: rtl/eei2c_line_sync.sv
module eei2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev,
  output logic sda_s
);
  logic [1:0] raw, cur, prv;
  assign raw = {scl_i, sda_i};

  genvar g;
  for (g = 0; g < 2; g++) begin : g_line
    logic [STAGES-1:0] pipe;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= '1;
      else        pipe <= {pipe[STAGES-2:0], raw[g]};
    end
    assign cur[g] = pipe[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prv <= '1;
    else        prv <= cur;
  end

  // bit 1 is SCL, bit 0 is SDA
  assign scl_rise = cur[1] & ~prv[1];
  assign scl_fall = ~cur[1] & prv[1];
  assign start_ev = cur[1] & prv[1] & prv[0] & ~cur[0];
  assign stop_ev  = cur[1] & prv[1] & ~prv[0] & cur[0];
  assign sda_s    = cur[0];
endmodule

// File: rtl/eei2c_commit.sv
module eei2c_commit #(
  parameter int ADDR_W     = 9,
  parameter int PAGE_BYTES = 16,
  parameter int IDX_W      = $clog2(PAGE_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fill_we,
  input  logic [IDX_W-1:0]  fill_idx,
  input  logic [7:0]        fill_data,
  input  logic              go,
  input  logic              go_erase,
  input  logic [ADDR_W-1:0] go_addr,
  input  logic [IDX_W:0]    go_count,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              wr_erase,
  output logic              pending
);
  logic [7:0]        page_q [PAGE_BYTES];
  logic              active, erase_q;
  logic [ADDR_W-1:0] base_q;
  logic [IDX_W:0]    count_q, sent_q;

  always_ff @(posedge clk) begin
    if (fill_we) page_q[fill_idx] <= fill_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      erase_q <= 1'b0;
      base_q  <= '0;
      count_q <= '0;
      sent_q  <= '0;
    end else if (go) begin
      active  <= 1'b1;
      erase_q <= go_erase;
      base_q  <= go_addr;
      count_q <= go_count;
      sent_q  <= '0;
    end else if (active && wr_ready) begin
      if (erase_q || (sent_q + 1'b1 == count_q)) active <= 1'b0;
      sent_q <= sent_q + 1'b1;
    end
  end

  assign wr_valid = active;
  assign wr_erase = erase_q;
  assign wr_addr  = base_q + ADDR_W'(sent_q);
  assign wr_data  = page_q[sent_q[IDX_W-1:0]];
  assign pending  = active;
endmodule

// File: rtl/eei2c_slave.sv
module eei2c_slave
  import eei2c_pkg::*;
#(
  parameter int         ADDR_W      = 9,
  parameter int         PAGE_BYTES  = 16,
  parameter logic [3:0] DEV_HI      = 4'b1010,
  parameter bit         ERASE_ON_A2 = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pull_o,
  input  logic [2:0]        dev_pins,
  input  logic              wp_i,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              wr_erase,
  input  logic              mem_busy,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        rd_data
);
  localparam int         EXT      = ADDR_W - 8;
  localparam int         IDX_W    = $clog2(PAGE_BYTES);
  localparam int         CNT_W    = IDX_W + 1;
  localparam logic [2:0] PIN_MASK = 3'(3'b111 << EXT);

  logic scl_rise, scl_fall, start_ev, stop_ev, sda_s;

  eei2c_line_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev), .sda_s(sda_s)
  );

  phase_e            st;
  logic [3:0]        bitcnt;
  logic [7:0]        sh, tx;
  logic              tx_en, ack_q, mack, first;
  logic              erase_mode, erase_armed;
  logic [2:0]        ext_q;
  logic [ADDR_W-1:0] ptr, wbase, eaddr;
  logic [CNT_W-1:0]  wcnt;
  logic              pending, busy, go, fill_we, accept, is_erase, dev_hit;
  logic [2:0]        cmp_mask;
  logic [ADDR_W-1:0] byte_addr;

  assign busy      = pending | mem_busy;
  assign is_erase  = ERASE_ON_A2 && sh[3] && !sh[0];
  assign cmp_mask  = is_erase ? (PIN_MASK & 3'b011) : PIN_MASK;
  assign dev_hit   = (sh[7:4] == DEV_HI) && (((sh[3:1] ^ dev_pins) & cmp_mask) == 3'b000);
  assign byte_addr = ADDR_W'({ext_q, sh});
  assign accept    = !erase_mode && !wp_i && (wcnt != CNT_W'(PAGE_BYTES));
  assign fill_we   = scl_fall && (bitcnt == 4'd8) && (st == ST_WDATA) && accept;
  assign go        = stop_ev && (erase_armed || (wcnt != '0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; bitcnt <= '0; sh <= '0; tx <= '0; tx_en <= 1'b0;
      ack_q <= 1'b0; mack <= 1'b0; first <= 1'b0; ptr <= '0; wbase <= '0;
      eaddr <= '0; wcnt <= '0; erase_mode <= 1'b0; erase_armed <= 1'b0;
      ext_q <= '0;
    end else if (start_ev) begin
      st <= ST_DEV; bitcnt <= '0; ack_q <= 1'b0; tx_en <= 1'b0;
      wcnt <= '0; erase_armed <= 1'b0; erase_mode <= 1'b0;
    end else if (stop_ev) begin
      st <= ST_IDLE; bitcnt <= '0; ack_q <= 1'b0; tx_en <= 1'b0;
      wcnt <= '0; erase_armed <= 1'b0;
    end else if (st != ST_IDLE && st != ST_IGNORE) begin
      if (scl_rise) begin
        if (bitcnt < 4'd8) sh <= {sh[6:0], sda_s};
        else               mack <= ~sda_s;
        bitcnt <= bitcnt + 4'd1;
      end
      if (scl_fall) begin
        if (bitcnt == 4'd9) begin
          bitcnt <= '0;
          ack_q  <= 1'b0;
          if (st == ST_RDATA) begin
            if (first || mack) begin
              tx    <= rd_data;
              tx_en <= 1'b1;
              ptr   <= ptr + ADDR_W'(1);
              first <= 1'b0;
            end else begin
              st <= ST_IGNORE;
            end
          end
        end else if (st == ST_RDATA) begin
          if (bitcnt == 4'd8)      tx_en <= 1'b0;
          else if (bitcnt != 4'd0) tx <= {tx[6:0], 1'b0};
        end else if (bitcnt == 4'd8) begin
          case (st)
            ST_DEV: begin
              if (dev_hit && !busy) begin
                ack_q      <= 1'b1;
                ext_q      <= sh[3:1] & ~PIN_MASK;
                erase_mode <= is_erase;
                if (sh[0]) begin st <= ST_RDATA; first <= 1'b1; end
                else       st <= ST_ADDR;
              end else begin
                st <= ST_IGNORE;
              end
            end
            ST_ADDR: begin
              if (erase_mode) begin
                if (wp_i) st <= ST_IGNORE;
                else begin
                  ack_q <= 1'b1; erase_armed <= 1'b1; eaddr <= byte_addr;
                  st <= ST_WDATA;
                end
              end else begin
                ack_q <= 1'b1; ptr <= byte_addr; wbase <= byte_addr;
                st <= ST_WDATA;
              end
            end
            ST_WDATA: begin
              if (accept) begin
                ack_q <= 1'b1;
                wcnt  <= wcnt + CNT_W'(1);
                ptr   <= ptr + ADDR_W'(1);
              end else begin
                st <= ST_IGNORE;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  assign sda_pull_o = ack_q | (tx_en & ~tx[7]);
  assign rd_addr    = ptr;

  eei2c_commit #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .IDX_W(IDX_W)) u_commit (
    .clk(clk), .rst_n(rst_n),
    .fill_we(fill_we), .fill_idx(wcnt[IDX_W-1:0]), .fill_data(sh),
    .go(go), .go_erase(erase_armed), .go_addr(erase_armed ? eaddr : wbase),
    .go_count(wcnt),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_erase(wr_erase), .pending(pending)
  );
endmodule

// File: rtl/eei2c_slave_chk.sv
module eei2c_slave_chk #(
  parameter int ADDR_W     = 9,
  parameter int PAGE_BYTES = 16,
  parameter int CNT_W      = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_i,
  input logic              sda_pull_o,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [7:0]        wr_data,
  input logic              wr_erase,
  input logic              stop_ev,
  input logic [CNT_W-1:0]  wcnt
);
  // R11
  sda_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_i && $past(scl_i)) |-> $stable(sda_pull_o));

  // R12
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data) && $stable(wr_erase)));

  // R4
  commit_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_valid) |-> $past(stop_ev));

  // R5
  page_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wcnt <= CNT_W'(PAGE_BYTES));
endmodule

bind eei2c_slave eei2c_slave_chk #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_pull_o(sda_pull_o),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
  .wr_data(wr_data), .wr_erase(wr_erase), .stop_ev(stop_ev), .wcnt(wcnt)
);

// File: tb/eei2c_slave_bench.sv
module eei2c_slave_bench;
  localparam int BUSY_CLK = 400;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       msda = 1'b1;
  logic       wp = 1'b0;
  logic       sda_pull_o, wr_valid, wr_ready, wr_erase, mem_busy;
  logic [8:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;
  wire        sda_bus = msda & ~sda_pull_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  eei2c_slave u_eei2c_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .sda_pull_o(sda_pull_o), .dev_pins(3'b000), .wp_i(wp),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_erase(wr_erase), .mem_busy(mem_busy),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  // memory model
  logic [7:0] mem [512];
  int busy_cnt;
  function automatic logic [7:0] init_val(input int a);
    return 8'(a * 7 + 3);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 512; k++) mem[k] <= init_val(k);
      busy_cnt <= 0;
    end else if (wr_valid && wr_ready) begin
      if (wr_erase) for (int k = 0; k < 256; k++) mem[{wr_addr[8], 8'(k)}] <= 8'hFF;
      else mem[wr_addr] <= wr_data;
      busy_cnt <= BUSY_CLK;
    end else if (busy_cnt > 0) begin
      busy_cnt <= busy_cnt - 1;
    end
  end
  assign mem_busy = (busy_cnt != 0);
  assign wr_ready = rst_n && (busy_cnt == 0);
  assign rd_data  = mem[rd_addr];

  // port monitors for R11 and R12
  int r11_bad = 0, r12_bad = 0;
  logic scl_p = 1'b1, pull_p = 1'b0, v_p = 1'b0, r_p = 1'b0, e_p = 1'b0;
  logic [8:0] a_p = '0;
  logic [7:0] d_p = '0;
  always @(posedge clk) begin
    if (rst_n) begin
      if (scl && scl_p && sda_pull_o != pull_p) r11_bad <= r11_bad + 1;
      if (v_p && !r_p && (!wr_valid || wr_addr != a_p || wr_data != d_p || wr_erase != e_p))
        r12_bad <= r12_bad + 1;
    end
    scl_p <= scl; pull_p <= sda_pull_o; v_p <= wr_valid; r_p <= wr_ready;
    a_p <= wr_addr; d_p <= wr_data; e_p <= wr_erase;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // bus primitives
  task automatic wait_q();
    repeat (5) @(posedge clk);
    #2;
  endtask
  task automatic bus_start();
    msda = 1'b1; wait_q(); scl = 1'b1; wait_q(); msda = 1'b0; wait_q(); scl = 1'b0; wait_q();
  endtask
  task automatic bus_stop();
    msda = 1'b0; wait_q(); scl = 1'b1; wait_q(); msda = 1'b1; wait_q();
  endtask
  task automatic send_bit(input bit b);
    msda = b; wait_q(); scl = 1'b1; wait_q(); wait_q(); scl = 1'b0; wait_q();
  endtask
  task automatic recv_bit(output bit b);
    msda = 1'b1; wait_q(); scl = 1'b1; wait_q(); b = sda_bus; wait_q(); scl = 1'b0; wait_q();
  endtask
  task automatic send_byte(input logic [7:0] d, output bit ack);
    bit b;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    recv_bit(b);
    ack = !b;
  endtask
  task automatic recv_byte(output logic [7:0] d, input bit give_ack);
    bit b;
    for (int i = 7; i >= 0; i--) begin recv_bit(b); d[i] = b; end
    send_bit(!give_ack);
  endtask
  task automatic poll_ready(output int tries);
    bit a = 1'b0;
    tries = 0;
    while (!a && tries < 60) begin
      bus_start(); send_byte(8'hA0, a); bus_stop(); tries++;
    end
  endtask

  // scenarios
  task automatic t_reset();
    check(sda_pull_o == 1'b0, "R1 sda released", sda_pull_o, 0);
    check(wr_valid == 1'b0, "R1 no request", wr_valid, 0);
  endtask

  task automatic t_mismatch();
    bit a;
    bus_start(); send_byte(8'hB0, a); bus_stop();
    check(!a, "R2 wrong upper nibble acked", a, 0);
    bus_start(); send_byte(8'hA4, a); bus_stop();
    check(!a, "R2 wrong A1 acked", a, 0);
  endtask

  task automatic t_byte_write();
    bit a0, a1, a2, ap; int tries;
    bus_start(); send_byte(8'hA0, a0); send_byte(8'h10, a1); send_byte(8'h3C, a2);
    check(a0 && a1 && a2, "R4 byte write acks", {a0, a1, a2}, 7);
    repeat (50) @(posedge clk);
    check(mem[9'h010] == init_val(16), "R4 written before stop", mem[9'h010], init_val(16));
    bus_stop();
    bus_start(); send_byte(8'hA0, ap); bus_stop();
    check(!ap, "R6 acked while busy", ap, 0);
    poll_ready(tries);
    check(tries > 0 && tries < 60, "R6 poll never acked", tries, 1);
    check(mem[9'h010] == 8'h3C, "R4 byte committed", mem[9'h010], 8'h3C);
  endtask

  task automatic t_page();
    bit a; int tries; int ok = 1;
    bus_start(); send_byte(8'hA0, a); send_byte(8'h20, a);
    for (int i = 0; i < 4; i++) begin send_byte(8'(8'h11 * (i + 1)), a); if (!a) ok = 0; end
    bus_stop(); poll_ready(tries);
    check(ok == 1, "R5 page bytes acked", ok, 1);
    for (int i = 0; i < 4; i++)
      check(mem[9'h020 + i] == 8'(8'h11 * (i + 1)), "R5 page content", mem[9'h020 + i], 8'h11 * (i + 1));
  endtask

  task automatic t_overflow();
    bit a; int tries; int nacks = 0; bit last = 1'b1;
    bus_start(); send_byte(8'hA0, a); send_byte(8'h40, a);
    for (int i = 0; i < 17; i++) begin
      send_byte(8'(8'h80 + i), a);
      if (i < 16 && !a) nacks++;
      if (i == 16) last = a;
    end
    bus_stop(); poll_ready(tries);
    check(nacks == 0, "R5 in-page byte nacked", nacks, 0);
    check(!last, "R5 excess byte acked", last, 0);
    check(mem[9'h04F] == 8'h8F, "R5 last page byte", mem[9'h04F], 8'h8F);
    check(mem[9'h050] == init_val(9'h050), "R5 excess byte written", mem[9'h050], init_val(9'h050));
  endtask

  task automatic t_reads();
    bit a; logic [7:0] d0, d1, d2, d3;
    bus_start(); send_byte(8'hA0, a); send_byte(8'h20, a);
    bus_start(); send_byte(8'hA1, a);
    check(a, "R9 read address acked", a, 1);
    recv_byte(d0, 1'b1); recv_byte(d1, 1'b1); recv_byte(d2, 1'b0);
    check(d0 == 8'h11, "R9 random read", d0, 8'h11);
    check(d1 == 8'h22 && d2 == 8'h33, "R9 sequential read", {d1, d2}, 16'h2233);
    repeat (10) @(posedge clk);
    check(sda_pull_o == 1'b0, "R9 released after nack", sda_pull_o, 0);
    bus_stop();
    bus_start(); send_byte(8'hA1, a); recv_byte(d3, 1'b0); bus_stop();
    check(d3 == 8'h44, "R9 current address read", d3, 8'h44);
  endtask

  task automatic t_a0_bit();
    bit a; int tries; logic [7:0] d;
    bus_start(); send_byte(8'hA2, a); send_byte(8'h05, a); send_byte(8'h5A, a); bus_stop();
    poll_ready(tries);
    check(mem[9'h105] == 8'h5A, "R3 upper half write", mem[9'h105], 8'h5A);
    check(mem[9'h005] == init_val(5), "R3 lower half touched", mem[9'h005], init_val(5));
    bus_start(); send_byte(8'hA2, a); send_byte(8'h05, a);
    bus_start(); send_byte(8'hA3, a); recv_byte(d, 1'b0); bus_stop();
    check(d == 8'h5A, "R3 upper half read", d, 8'h5A);
  endtask

  task automatic t_wp();
    bit a0, a1, a2, ap;
    wp = 1'b1;
    bus_start(); send_byte(8'hA0, a0); send_byte(8'h30, a1); send_byte(8'h99, a2); bus_stop();
    check(a0 && a1, "R7 address bytes acked", {a0, a1}, 3);
    check(!a2, "R7 data byte acked", a2, 0);
    bus_start(); send_byte(8'hA0, ap); bus_stop();
    check(ap, "R7 busy after protected write", ap, 1);
    check(mem[9'h030] == init_val(9'h030), "R7 write happened", mem[9'h030], init_val(9'h030));
    wp = 1'b0;
  endtask

  task automatic t_restart();
    bit a, ap;
    bus_start(); send_byte(8'hA0, a); send_byte(8'h60, a); send_byte(8'hEE, a);
    bus_start(); bus_stop();
    repeat (300) @(posedge clk);
    bus_start(); send_byte(8'hA0, ap); bus_stop();
    check(ap, "R10 commit after restart", ap, 1);
    check(mem[9'h060] == init_val(9'h060), "R10 discarded data written", mem[9'h060], init_val(9'h060));
  endtask

  task automatic t_erase();
    bit a0, a1; int tries;
    wp = 1'b1;
    bus_start(); send_byte(8'hAA, a0); send_byte(8'h00, a1); bus_stop();
    check(a0 && !a1, "R8 protected erase address", {a0, a1}, 2);
    repeat (300) @(posedge clk);
    check(mem[9'h105] == 8'h5A, "R8 protected erase ran", mem[9'h105], 8'h5A);
    wp = 1'b0;
    bus_start(); send_byte(8'hAA, a0); send_byte(8'h00, a1); bus_stop();
    check(a0 && a1, "R8 erase acks", {a0, a1}, 3);
    poll_ready(tries);
    check(mem[9'h105] == 8'hFF && mem[9'h1F0] == 8'hFF, "R8 sector erased", mem[9'h105], 8'hFF);
    check(mem[9'h010] == 8'h3C, "R8 other sector hit", mem[9'h010], 8'h3C);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (5) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (5) @(posedge clk);
    #2;
    t_reset();
    t_mismatch();
    t_byte_write();
    t_page();
    t_overflow();
    t_reads();
    t_a0_bit();
    t_wp();
    t_restart();
    t_erase();
    check(r11_bad == 0, "R11 sda moved with scl high", r11_bad, 0);
    check(r12_bad == 0, "R12 beat changed under backpressure", r12_bad, 0);
    summary();
  end
endmodule